// File: doc/BRIEF.md
# Set-Associative Write-Through Data Cache Tag Controller

This block is the tag side of a processor's level-one data cache. It keeps, for each set, a tag and a valid bit per way and a full recency order of the ways. Loads and stores arrive one at a time on a request port. A hit is answered a fixed number of cycles after the request was taken. A miss is answered one cycle after acceptance with a negative response. In that same cycle a line request is issued to a separate miss-tracking unit, so the pipeline can continue with other work. Later, the miss-tracking unit hands back a filled line on a fill port, and the block installs it in a free way or in the least recently touched way of its set.

Stores always go to memory through a write-through strobe, whether they hit or miss. Loads and stores both allocate on a miss. Because lines are never dirty, an evicted line is simply dropped. A bypass input makes every access report a hit with no miss request and no change to cache state, so the memory hierarchy can be treated as ideal. Two counters tally hits and misses.

The control is one four-state machine:
- **IDLE** takes a fill, or else a request. IDLE→LOOKUP on an accepted request.
- **LOOKUP** compares tags. On a miss it goes LOOKUP→IDLE. On a hit it goes LOOKUP→WAIT, or LOOKUP→RESP when the latency is 2.
- **WAIT** counts down. It goes WAIT→RESP when the count runs out.
- **RESP** signals the hit response. It goes RESP→IDLE.

Fills are installed in IDLE without leaving that state.

Top module: `dcache_wt`

## Requirements
- R1: An address splits into a 6-bit byte offset (bits 5:0), a set index of log2(CAP_KB*1024/WAYS/64) bits above the offset, and the tag in the remaining upper bits. With the defaults (1 KB, 4 ways) there are 4 sets, indexed by bits 7:6.
- R2: A hit raises `resp_valid` with `resp_hit`=1 exactly HIT_LAT cycles (default 5) after the clock edge that accepted the request.
- R3: A miss raises `resp_valid` with `resp_hit`=0 one cycle after acceptance. In that same cycle it raises `miss_valid`, with `miss_addr` equal to the request address with bits 5:0 cleared.
- R4: Every store raises `wt_valid` with `wt_addr` equal to the full request address in the cycle after acceptance. This happens on a hit, on a miss and in bypass mode. Loads never raise it.
- R5: Load misses and store misses both request the line. After the line is filled through `fill_line` (the address shifted right by 6), any access to any byte of that line hits.
- R6: Hits and fills make the touched way the most recently used. When a fill finds its set full, it replaces the least recently touched way.
- R7: When a set has invalid ways, a fill uses the lowest-numbered invalid way. It evicts no valid line.
- R8: A fill whose line is already present installs no second copy and evicts nothing. It only marks that way most recently used.
- R9: While `perfect_i` is 1, every access hits after HIT_LAT cycles. No miss request is made, and tags, valid bits and recency are left unchanged.
- R10: `hit_count` and `miss_count` each increase by one per access, according to that access's outcome.
- R11: `req_ready` is 1 only in IDLE when no fill is offered. A fill offered in IDLE is taken first, and `fill_ready` is 1 only in IDLE.
- R12: After reset, all ways are invalid, the machine is in IDLE with `req_ready`=1, no response, miss or write strobe is active, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perfect_i | input | 1 | Bypass: force every access to hit |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| resp_valid | output | 1 | Access outcome available |
| resp_hit | output | 1 | Outcome: 1 hit, 0 miss |
| miss_valid | output | 1 | Line request to the miss tracker |
| miss_addr | output | ADDR_W | Line-aligned address of the missing line |
| wt_valid | output | 1 | Store forwarded to memory |
| wt_addr | output | ADDR_W | Address of the forwarded store |
| fill_valid | input | 1 | Returned line to install |
| fill_ready | output | 1 | Fill taken on this edge if valid |
| fill_line | input | ADDR_W-6 | Line address of the returned line |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A wrong recency order does not show until a later fill into a full set evicts the wrong line. A following access to the line that should have stayed then reports a miss, and its response arrives 1 cycle after acceptance instead of HIT_LAT. Stale or lost valid bits likewise show only on the next access to that line, as a response of the wrong kind together with a spurious or missing line request. A wrong latency count in WAIT shows at once in the first hit, and a wrong counter update shows in the tallies at the end of the sequence.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int LINE_BYTES = 64;
    localparam int OFF_W      = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RESP   = 2'd3
    } dc_state_t;

endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  inv_vec,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];

    // valid bits are reset, tags are not
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
        end
    end

    // one comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g] = valid_q[rd_idx][g] && (tag_q[rd_idx][g] == rd_tag);
        assign inv_vec[g] = !valid_q[rd_idx][g];
    end

endmodule

// File: rtl/dc_lru_array.sv
module dc_lru_array #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAYS-1:0]  inv_vec,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);

    // age 0 = most recent, WAYS-1 = least recent; ages in a set are a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[idx][w] <= '0;
                end else if (age_q[idx][w] < age_q[idx][touch_way]) begin
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
                end
            end
        end
    end

    // lowest invalid way first, oldest way otherwise
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && inv_vec[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[idx][w] == WAY_W'(WAYS - 1)) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
    import dcache_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CAP_KB  = 1,
    parameter int WAYS    = 4,
    parameter int HIT_LAT = 5,
    parameter int CNT_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    perfect_i,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic                    miss_valid,
    output logic [ADDR_W-1:0]       miss_addr,
    output logic                    wt_valid,
    output logic [ADDR_W-1:0]       wt_addr,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [ADDR_W-OFF_W-1:0] fill_line,
    output logic [CNT_W-1:0]        hit_count,
    output logic [CNT_W-1:0]        miss_count
);

    localparam int SETS      = CAP_KB * 1024 / WAYS / LINE_BYTES;
    localparam int IDX_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WAIT_W    = (HIT_LAT > 2) ? $clog2(HIT_LAT) : 1;
    localparam int WAIT_INIT = (HIT_LAT > 2) ? HIT_LAT - 3 : 0;

    dc_state_t         st_q, st_nx;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              cur_write_q;
    logic [WAIT_W-1:0] wait_q;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WAYS-1:0]   hit_vec, inv_vec;
    logic              any_hit, eff_hit;
    logic [WAY_W-1:0]  hit_way, victim;
    logic              accept, fill_go, lookup;
    logic              tag_wr, touch_en;
    logic [WAY_W-1:0]  touch_way;

    // ---------------- lookup address select ----------------
    // fills use the array in IDLE, requests in LOOKUP
    always_comb begin
        if (st_q == ST_IDLE) begin
            lk_idx = fill_line[IDX_W-1:0];
            lk_tag = fill_line[ADDR_W-OFF_W-1:IDX_W];
        end else begin
            lk_idx = cur_addr_q[OFF_W +: IDX_W];
            lk_tag = cur_addr_q[ADDR_W-1:OFF_W+IDX_W];
        end
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign any_hit   = |hit_vec;
    assign eff_hit   = perfect_i || any_hit;
    assign fill_go   = (st_q == ST_IDLE) && fill_valid;
    assign accept    = (st_q == ST_IDLE) && !fill_valid && req_valid;
    assign lookup    = (st_q == ST_LOOKUP);
    assign tag_wr    = fill_go && !any_hit;
    assign touch_en  = fill_go || (lookup && any_hit && !perfect_i);
    assign touch_way = tag_wr ? victim : hit_way;

    // ---------------- storage ----------------
    dc_tag_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_tag  (lk_tag),
        .hit_vec (hit_vec),
        .inv_vec (inv_vec),
        .wr_en   (tag_wr),
        .wr_idx  (lk_idx),
        .wr_way  (victim),
        .wr_tag  (lk_tag)
    );

    dc_lru_array #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (lk_idx),
        .inv_vec   (inv_vec),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .victim    (victim)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) st_nx = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (!eff_hit)          st_nx = ST_IDLE;
                else if (HIT_LAT <= 2) st_nx = ST_RESP;
                else                   st_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_q == '0) st_nx = ST_RESP;
            end
            ST_RESP: begin
                st_nx = ST_IDLE;
            end
        endcase
    end

    // ---------------- request and latency registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            cur_write_q <= 1'b0;
            wait_q      <= '0;
        end else begin
            if (accept) begin
                cur_addr_q  <= req_addr;
                cur_write_q <= req_write;
            end
            if (lookup) begin
                wait_q <= WAIT_W'(WAIT_INIT);
            end else if (st_q == ST_WAIT && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (lookup) begin
            if (eff_hit) hit_count  <= hit_count + CNT_W'(1);
            else         miss_count <= miss_count + CNT_W'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = 1'b0;
        fill_ready = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        miss_valid = 1'b0;
        wt_valid   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                fill_ready = 1'b1;
                req_ready  = !fill_valid;
            end
            ST_LOOKUP: begin
                wt_valid = cur_write_q;
                if (!eff_hit) begin
                    resp_valid = 1'b1;
                    miss_valid = 1'b1;
                end
            end
            ST_WAIT: begin
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                resp_hit   = 1'b1;
            end
        endcase
    end

    assign miss_addr = {cur_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign wt_addr   = cur_addr_q;

endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
    parameter int HIT_LAT = 5,
    parameter int CNT_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             miss_valid,
    input logic             wt_valid,
    input logic [CNT_W-1:0] miss_count
);

    // cycles since the accepting edge; 0 when no access is in flight
    logic [15:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (req_valid && req_ready) begin
            since_q <= 16'd1;
        end else if (resp_valid) begin
            since_q <= '0;
        end else if (since_q != '0 && since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    a_r2_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (since_q == 16'(HIT_LAT)));

    a_r3_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (since_q == 16'd1));

    a_r3_miss_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (resp_valid && !resp_hit));

    a_r4_wt_timing: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> (since_q == 16'd1));

    a_r10_miss_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> (miss_count == $past(miss_count) + CNT_W'(1)));

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind dcache_wt dcache_wt_chk #(
    .HIT_LAT (HIT_LAT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .miss_valid (miss_valid),
    .wt_valid   (wt_valid),
    .miss_count (miss_count)
);

// File: tb/test_dcache_wt.sv
module test_dcache_wt;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int HIT_LAT    = 5;
    localparam int CNT_W      = 32;
    localparam int NVEC       = 20;

    // {op, addr, expected hit}; op 0 load, 1 store, 2 fill
    // 4 sets: set index = addr[7:6], tag = addr[31:8]
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 32'h0000_0100, 1'b0},  // R12/R7 empty cache: miss
        {2'd2, 32'h0000_0100, 1'b0},  // R5 fill A1 -> way0
        {2'd0, 32'h0000_013C, 1'b1},  // R1/R5 other byte of line hits
        {2'd1, 32'h0000_0100, 1'b1},  // R4 store hit, written through
        {2'd2, 32'h0000_0200, 1'b0},  // R7 fill A2 -> way1
        {2'd2, 32'h0000_0300, 1'b0},  // R7 fill A3 -> way2
        {2'd2, 32'h0000_0400, 1'b0},  // R7 fill A4 -> way3
        {2'd0, 32'h0000_0100, 1'b1},  // R6 touch A1, A2 now oldest
        {2'd2, 32'h0000_0500, 1'b0},  // R6 fill A5 evicts A2
        {2'd0, 32'h0000_0200, 1'b0},  // R6 A2 gone
        {2'd0, 32'h0000_0100, 1'b1},  // R6 A1 kept
        {2'd0, 32'h0000_0300, 1'b1},  // R7 A3 kept
        {2'd0, 32'h0000_0400, 1'b1},  // R7 A4 kept
        {2'd0, 32'h0000_0500, 1'b1},  // R6 A5 present
        {2'd2, 32'h0000_0600, 1'b0},  // R6 fill A6 evicts A1
        {2'd0, 32'h0000_0100, 1'b0},  // R6 A1 gone
        {2'd0, 32'h0000_0600, 1'b1},  // R6 A6 present
        {2'd2, 32'h0000_0600, 1'b0},  // R8 duplicate fill of A6
        {2'd0, 32'h0000_0300, 1'b1},  // R8 A3 (oldest) not evicted
        {2'd1, 32'h0000_0740, 1'b0}   // R4/R5 store miss in set 1
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                perfect_i = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic                resp_valid, resp_hit;
    logic                miss_valid, wt_valid;
    logic [ADDR_W-1:0]   miss_addr, wt_addr;
    logic                fill_valid = 1'b0;
    logic                fill_ready;
    logic [ADDR_W-7:0]   fill_line = '0;
    logic [CNT_W-1:0]    hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_misses = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_wt #(
        .ADDR_W  (ADDR_W),
        .CAP_KB  (1),
        .WAYS    (4),
        .HIT_LAT (HIT_LAT),
        .CNT_W   (CNT_W)
    ) i_dcache_wt (
        .clk        (clk),
        .rst_n      (rst_n),
        .perfect_i  (perfect_i),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .miss_valid (miss_valid),
        .miss_addr  (miss_addr),
        .wt_valid   (wt_valid),
        .wt_addr    (wt_addr),
        .fill_valid (fill_valid),
        .fill_ready (fill_ready),
        .fill_line  (fill_line),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // follows one accepted access until its response; call right after the accepting edge
    task automatic observe(input bit wr, input logic [ADDR_W-1:0] addr, input bit exp_hit,
                           input string tag);
        int lat = 0;
        bit miss_seen = 1'b0;
        bit wt_seen = 1'b0;
        logic [ADDR_W-1:0] m_addr = '0;
        logic [ADDR_W-1:0] w_addr = '0;
        bit got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (miss_valid) begin miss_seen = 1'b1; m_addr = miss_addr; end
            if (wt_valid)   begin wt_seen = 1'b1;   w_addr = wt_addr;   end
            if (resp_valid) begin
                got = 1'b1;
                chk(resp_hit == exp_hit, {tag, " R5/R6 outcome"}, resp_hit, exp_hit);
            end
        end
        chk(got, {tag, " R2 response seen"}, got, 1);
        if (exp_hit) chk(lat == HIT_LAT, {tag, " R2 hit latency"}, lat, HIT_LAT);
        else         chk(lat == 1, {tag, " R3 miss latency"}, lat, 1);
        chk(miss_seen == !exp_hit, {tag, " R3 miss request"}, miss_seen, !exp_hit);
        if (miss_seen)
            chk(m_addr == {addr[ADDR_W-1:6], 6'b0}, {tag, " R3 miss address"}, m_addr,
                {addr[ADDR_W-1:6], 6'b0});
        chk(wt_seen == wr, {tag, " R4 write-through strobe"}, wt_seen, wr);
        if (wt_seen) chk(w_addr == addr, {tag, " R4 write-through address"}, w_addr, addr);
        if (exp_hit) exp_hits++; else exp_misses++;
    endtask

    task automatic access(input bit wr, input logic [ADDR_W-1:0] addr, input bit exp_hit,
                          input string tag);
        wait_idle();
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        @(posedge clk);
        observe(wr, addr, exp_hit, tag);
    endtask

    task automatic fill(input logic [ADDR_W-1:0] addr);
        wait_idle();
        fill_valid = 1'b1;
        fill_line  = addr[ADDR_W-1:6];
        chk(fill_ready == 1'b1, "R11 fill_ready in IDLE", fill_ready, 1);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0 && miss_valid == 1'b0 && wt_valid == 1'b0,
            "R12 strobes idle after reset", {resp_valid, miss_valid, wt_valid}, 0);
        chk(hit_count == 0 && miss_count == 0, "R12 counters zero",
            hit_count + miss_count, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]        op;
            logic [ADDR_W-1:0] a;
            bit                eh;
            op = VEC[v][34:33];
            a  = VEC[v][32:1];
            eh = VEC[v][0];
            if (op == 2'd2) fill(a);
            else access(op == 2'd1, a, eh, $sformatf("vec%0d", v));
        end

        // R11: fill and request together; fill is taken first
        wait_idle();
        fill_valid = 1'b1;
        fill_line  = 26'h42;            // line 0x1080: set 2, tag 0x10
        req_valid  = 1'b1;
        req_write  = 1'b0;
        req_addr   = 32'h0000_1080;
        #1;
        chk(req_ready == 1'b0, "R11 request held while fill offered", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R11 request ready after fill", req_ready, 1);
        @(posedge clk);
        observe(1'b0, 32'h0000_1080, 1'b1, "prio");

        // R9 bypass mode
        perfect_i = 1'b1;
        access(1'b0, 32'h0000_0900, 1'b1, "perf_ld R9");
        access(1'b1, 32'h0000_0A40, 1'b1, "perf_st R9");
        perfect_i = 1'b0;
        access(1'b0, 32'h0000_0900, 1'b0, "post_perf R9");
        // R9: bypass did not disturb recency; A3 still present after A3 hit in table
        access(1'b0, 32'h0000_0300, 1'b1, "post_perf_keep R9");

        // R10 counters
        wait_idle();
        chk(hit_count == CNT_W'(exp_hits), "R10 hit counter", hit_count, exp_hits);
        chk(miss_count == CNT_W'(exp_misses), "R10 miss counter", miss_count, exp_misses);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule